// File: doc/BRIEF.md
# Two-Class Prioritized Interrupt Controller

This block gathers up to 64 level-sensitive interrupt lines and turns them into two processor requests: a fast request and a normal request. Software gives every line a class (fast, normal or off) through a small word-addressed register bus. For each class the block keeps a registered "winner" register. This register names the most urgent pending line of that class, so a handler can read one word instead of scanning status.

Urgency follows a mixed scheme. Lines 0–7 form a group whose internal order comes from a table of eight 3-bit slots. The table maps rank to line number. As a group, lines 0–7 rank above every line from 8 upward. Lines 8 and above rank by index, and a lower index wins. A single boost bit lifts all of lines 32–63 above all of lines 0–31, with index order inside the upper half. Synchronizing the inputs and detecting edges are left to the logic in front of the block.

Top module: `irq_two_class_ctrl`

## Requirements
- R1: After reset the class words (addresses 0–3) read 0, the slot table (address 4) reads 0x00FAC688 (slot k holds k), the boost word (address 5) reads 0, and both winner words (addresses 10 and 11) read 0.
- R2: Line i has a 2-bit class field at address i/16, bits [2*(i%16)+1 : 2*(i%16)]. The value 01 means normal, 10 means fast, and 00 or 11 means off. `fiq_req` is high exactly when some pending line has class 10, and `irq_req` is high exactly when some pending line has class 01. Both requests follow the inputs with no register delay.
- R3: Address 6 returns the raw input level of lines 0–31 (line n at bit n), and address 7 returns lines 32–63 (line 32+n at bit n), whatever their class.
- R4: Addresses 8 and 9 return, in the same bit layout, the lines that are pending and whose class is 01 or 10.
- R5: Address 10 reports the fast-class winner and address 11 the normal-class winner. The format is bit 31 = valid and bits 5:0 = line number, with all other bits 0. With nothing of that class to report, the word reads 0.
- R6: A winner word reflects the inputs and configuration sampled at the previous rising clock edge, so it changes one cycle after the request output does.
- R7: With boost off, a pending line from 0–7 beats every line from 8 up, and among lines 8–63 the lowest index wins.
- R8: In the slot table at address 4, slot k occupies bits [3k+2:3k] and holds a line number 0–7, with slot 0 the most urgent. The winner within lines 0–7 is the line named by the lowest-numbered slot that names a pending line of that class. A line 0–7 named by no slot still drives its request output but is never reported.
- R9: With boost on (address 5, bit 0), any pending line 32–63 beats every line 0–31, and the lowest index among lines 32–63 wins. Below them the order of R7 and R8 still applies.
- R10: The two classes are judged independently: a line of one class never affects the other class's winner word or request output.
- R11: The class words read back exactly as written. The slot table reads back bits 23:0 of the written value with the upper bits 0, the boost word reads back only bit 0, and addresses 12–15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level-sensitive interrupt lines, already synchronized |
| bus_wr | input | 1 | Write strobe; bus_wdata is stored at bus_addr on the rising edge |
| bus_addr | input | 4 | Word address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fiq_req | output | 1 | Fast-class request |
| irq_req | output | 1 | Normal-class request |

## Verification
The bench builds the controller with its default NSRC of 64, so the upper half that the boost bit lifts is fully populated. This lets line 63 win the normal class. With this width, both status word pairs and all four class words carry live bits. The vector table places upper-half lines against lower-half lines with boost on and off, and the directed part reprograms the slot table, including one table that leaves most low lines unnamed.

// File: rtl/itc_pkg.sv
// Package: shared constants, class encoding and register map for the
// two-class interrupt controller. Assumes a 32-bit register bus and
// at most 64 interrupt lines.
package itc_pkg;
    localparam int MAX_SRC = 64;
    localparam int IDX_W   = $clog2(MAX_SRC);
    localparam int LOW_N   = 8;
    localparam int SLOT_W  = $clog2(LOW_N);
    localparam int TBL_W   = LOW_N * SLOT_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CLS_WORDS = (2 * MAX_SRC) / DATA_W;
    localparam int SPLIT   = 32;

    typedef enum logic [1:0] {
        CLS_OFF  = 2'b00,
        CLS_NORM = 2'b01,
        CLS_FAST = 2'b10,
        CLS_OFF2 = 2'b11
    } cls_e;

    localparam logic [ADDR_W-1:0] A_SLOTS   = 4'd4;
    localparam logic [ADDR_W-1:0] A_BOOST   = 4'd5;
    localparam logic [ADDR_W-1:0] A_RAW_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_RAW_HI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_MSK_LO  = 4'd8;
    localparam logic [ADDR_W-1:0] A_MSK_HI  = 4'd9;
    localparam logic [ADDR_W-1:0] A_WIN_FST = 4'd10;
    localparam logic [ADDR_W-1:0] A_WIN_NRM = 4'd11;

    // Slot table with slot k naming line k.
    function automatic logic [TBL_W-1:0] slot_identity();
        logic [TBL_W-1:0] t;
        t = '0;
        for (int k = 0; k < LOW_N; k++) begin
            t[k*SLOT_W +: SLOT_W] = SLOT_W'(k);
        end
        return t;
    endfunction
endpackage

// File: rtl/itc_regfile.sv
// Configuration storage: per-line class words, the low-group slot table
// and the boost bit. Assumes single-cycle writes with no wait states;
// the read mux lives in the top module.
module itc_regfile
    import itc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [CLS_WORDS-1:0][DATA_W-1:0]  cls_q,
    output logic [TBL_W-1:0]                  slots_q,
    output logic                              boost_q
);
    // Class words: reset to all-off, written by word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= '0;
        end else if (wr_en && addr < ADDR_W'(CLS_WORDS)) begin
            cls_q[addr[$clog2(CLS_WORDS)-1:0]] <= wdata;
        end
    end

    // Slot table and boost bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= slot_identity();
            boost_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_SLOTS) slots_q <= wdata[TBL_W-1:0];
            if (addr == A_BOOST) boost_q <= wdata[0];
        end
    end
endmodule

// File: rtl/itc_arbiter.sv
// Per-class winner selection. Takes the lines already masked to one
// class, finds the most urgent one under the slot/index/boost scheme,
// and registers the result. Assumes pend_i is zero above the line count.
module itc_arbiter
    import itc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_SRC-1:0]   pend_i,
    input  logic [TBL_W-1:0]     slots_i,
    input  logic                 boost_i,
    output logic                 req_o,
    output logic [IDX_W-1:0]     idx_q,
    output logic                 valid_q
);
    logic             low_hit, mid_hit, up_hit;
    logic [IDX_W-1:0] low_idx, mid_idx, up_idx;
    logic             nxt_v;
    logic [IDX_W-1:0] nxt_i;

    // Request: any line of this class pending.
    assign req_o = |pend_i;

    // Low group: the lowest slot naming a pending line wins.
    always_comb begin
        logic [SLOT_W-1:0] s;
        low_hit = 1'b0;
        low_idx = '0;
        for (int k = LOW_N - 1; k >= 0; k--) begin
            s = slots_i[k*SLOT_W +: SLOT_W];
            if (pend_i[{{(IDX_W-SLOT_W){1'b0}}, s}]) begin
                low_hit = 1'b1;
                low_idx = {{(IDX_W-SLOT_W){1'b0}}, s};
            end
        end
    end

    // Middle (LOW_N..SPLIT-1) and upper (SPLIT..MAX_SRC-1): lowest index wins.
    always_comb begin
        mid_hit = 1'b0;
        mid_idx = '0;
        up_hit  = 1'b0;
        up_idx  = '0;
        for (int i = SPLIT - 1; i >= LOW_N; i--) begin
            if (pend_i[i]) begin
                mid_hit = 1'b1;
                mid_idx = IDX_W'(i);
            end
        end
        for (int i = MAX_SRC - 1; i >= SPLIT; i--) begin
            if (pend_i[i]) begin
                up_hit = 1'b1;
                up_idx = IDX_W'(i);
            end
        end
    end

    // Group ordering, chosen by the boost bit.
    always_comb begin
        nxt_v = low_hit | mid_hit | up_hit;
        nxt_i = '0;
        if (boost_i && up_hit)   nxt_i = up_idx;
        else if (low_hit)        nxt_i = low_idx;
        else if (mid_hit)        nxt_i = mid_idx;
        else if (up_hit)         nxt_i = up_idx;
    end

    // Winner register: zero when nothing is reportable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= nxt_v;
            idx_q   <= nxt_v ? nxt_i : '0;
        end
    end

    assert_idle_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> idx_q == '0);

    assert_valid_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && valid_q) |-> $past(req_o));

    assert_low_group_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(boost_i) && $past(low_hit)) |-> (valid_q && idx_q < IDX_W'(LOW_N)));

    assert_boost_lifts_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(boost_i) && $past(|pend_i[MAX_SRC-1:SPLIT]))
            |-> (valid_q && idx_q >= IDX_W'(SPLIT)));
endmodule

// File: rtl/irq_two_class_ctrl.sv
// Top level: pads the input lines to the full width, decodes each line's
// class, runs one arbiter per class and serves register reads.
// Assumes inputs are already synchronized and level-sensitive.
module irq_two_class_ctrl
    import itc_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_i,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                fiq_req,
    output logic                irq_req
);
    logic [CLS_WORDS-1:0][DATA_W-1:0] cls_q;
    logic [2*MAX_SRC-1:0]             cls_flat;
    logic [TBL_W-1:0]                 slots_q;
    logic                             boost_q;
    logic [MAX_SRC-1:0]               raw, fast_p, norm_p;
    logic [IDX_W-1:0]                 fast_idx, norm_idx;
    logic                             fast_v, norm_v;

    assign cls_flat = cls_q;

    itc_regfile i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cls_q  (cls_q),
        .slots_q(slots_q),
        .boost_q(boost_q)
    );

    // Per-line padding and class split.
    for (genvar i = 0; i < MAX_SRC; i++) begin : g_line
        if (i < NSRC) begin : g_live
            assign raw[i] = src_i[i];
        end else begin : g_pad
            assign raw[i] = 1'b0;
        end
        assign fast_p[i] = raw[i] && (cls_e'(cls_flat[2*i +: 2]) == CLS_FAST);
        assign norm_p[i] = raw[i] && (cls_e'(cls_flat[2*i +: 2]) == CLS_NORM);
    end

    itc_arbiter i_arb_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (fast_p),
        .slots_i(slots_q),
        .boost_i(boost_q),
        .req_o  (fiq_req),
        .idx_q  (fast_idx),
        .valid_q(fast_v)
    );

    itc_arbiter i_arb_norm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (norm_p),
        .slots_i(slots_q),
        .boost_i(boost_q),
        .req_o  (irq_req),
        .idx_q  (norm_idx),
        .valid_q(norm_v)
    );

    // Read mux over configuration, status and winner words.
    always_comb begin
        logic [MAX_SRC-1:0] msk;
        msk = fast_p | norm_p;
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(CLS_WORDS)) begin
            bus_rdata = cls_q[bus_addr[$clog2(CLS_WORDS)-1:0]];
        end else begin
            case (bus_addr)
                A_SLOTS:   bus_rdata = {{(DATA_W-TBL_W){1'b0}}, slots_q};
                A_BOOST:   bus_rdata = {31'b0, boost_q};
                A_RAW_LO:  bus_rdata = raw[SPLIT-1:0];
                A_RAW_HI:  bus_rdata = raw[MAX_SRC-1:SPLIT];
                A_MSK_LO:  bus_rdata = msk[SPLIT-1:0];
                A_MSK_HI:  bus_rdata = msk[MAX_SRC-1:SPLIT];
                A_WIN_FST: bus_rdata = {fast_v, {(DATA_W-1-IDX_W){1'b0}}, fast_idx};
                A_WIN_NRM: bus_rdata = {norm_v, {(DATA_W-1-IDX_W){1'b0}}, norm_idx};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_class_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_p & norm_p) == '0);
endmodule

// File: tb/test_irq_two_class_ctrl.sv
module test_irq_two_class_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    typedef struct packed {
        logic [63:0] src;
        logic        boost;
        logic        fv;
        logic [5:0]  fi;
        logic        nv;
        logic [5:0]  ni;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{64'd0,                                        1'b0, 1'b0, 6'd0,  1'b0, 6'd0},
        '{(64'd1<<6),                                   1'b0, 1'b0, 6'd0,  1'b0, 6'd0},
        '{(64'd1<<3)|(64'd1<<1),                        1'b0, 1'b1, 6'd3,  1'b1, 6'd1},
        '{(64'd1<<9)|(64'd1<<8)|(64'd1<<4),             1'b0, 1'b1, 6'd4,  1'b1, 6'd8},
        '{(64'd1<<31)|(64'd1<<9),                       1'b0, 1'b1, 6'd9,  1'b0, 6'd0},
        '{(64'd1<<33)|(64'd1<<31)|(64'd1<<20),          1'b0, 1'b1, 6'd31, 1'b1, 6'd20},
        '{(64'd1<<33)|(64'd1<<31)|(64'd1<<20),          1'b1, 1'b1, 6'd33, 1'b1, 6'd20},
        '{(64'd1<<40)|(64'd1<<63)|(64'd1<<0)|(64'd1<<7),1'b0, 1'b1, 6'd7,  1'b1, 6'd0},
        '{(64'd1<<40)|(64'd1<<63)|(64'd1<<0)|(64'd1<<7),1'b1, 1'b1, 6'd7,  1'b1, 6'd40},
        '{(64'd1<<50)|(64'd1<<12),                      1'b0, 1'b0, 6'd0,  1'b0, 6'd0},
        '{(64'd1<<63)|(64'd1<<20),                      1'b1, 1'b0, 6'd0,  1'b1, 6'd63},
        '{(64'd1<<8)|(64'd1<<2),                        1'b0, 1'b0, 6'd0,  1'b1, 6'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fiq_req, irq_req;

    int total = 0;
    int fails = 0;
    logic [1:0] cls [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_two_class_ctrl #(.NSRC(64)) i_irq_two_class_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fiq_req(fiq_req), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] cls_word(input int w);
        logic [31:0] r;
        for (int j = 0; j < 16; j++) r[2*j +: 2] = cls[16*w + j];
        return r;
    endfunction

    function automatic logic [31:0] win(input logic v, input logic [5:0] i);
        return {v, 25'd0, i};
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] mexp;
        for (int i = 0; i < 64; i++) cls[i] = 2'b00;
        foreach (cls[i]) begin
            if (i inside {0, 1, 2, 5, 8, 20, 40, 63}) cls[i] = 2'b01;
            if (i inside {3, 4, 7, 9, 31, 33})        cls[i] = 2'b10;
        end
        cls[50] = 2'b11;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(4'(a), d); check("R1 class word", d, 32'h0);
        end
        bus_read(4'd4, d);  check("R1 slot table", d, 32'h00FAC688);
        bus_read(4'd5, d);  check("R1 boost", d, 32'h0);
        bus_read(4'd10, d); check("R1 fast winner", d, 32'h0);
        bus_read(4'd11, d); check("R1 normal winner", d, 32'h0);

        // R11 readback
        bus_write(4'd0, 32'hDEADBEEF);
        bus_read(4'd0, d);  check("R11 class readback", d, 32'hDEADBEEF);
        bus_write(4'd4, 32'hFFFFFFFF);
        bus_read(4'd4, d);  check("R11 slot readback", d, 32'h00FFFFFF);
        bus_write(4'd5, 32'hFFFFFFFF);
        bus_read(4'd5, d);  check("R11 boost readback", d, 32'h1);
        bus_read(4'd13, d); check("R11 unmapped", d, 32'h0);
        bus_write(4'd5, 32'h0);
        bus_write(4'd4, 32'h00FAC688);

        for (int w = 0; w < 4; w++) bus_write(4'(w), cls_word(w));

        // R3 raw status ignores class
        @(negedge clk);
        src = 64'hA5A50F0F_12348001;
        bus_read(4'd6, d); check("R3 raw low", d, 32'h12348001);
        bus_read(4'd7, d); check("R3 raw high", d, 32'hA5A50F0F);

        // R4 masked status
        src = '1;
        mexp = '0;
        for (int i = 0; i < 64; i++) mexp[i] = (cls[i] == 2'b01) || (cls[i] == 2'b10);
        bus_read(4'd8, d); check("R4 masked low", d, mexp[31:0]);
        bus_read(4'd9, d); check("R4 masked high", d, mexp[63:32]);

        // Table walk: R2 R5 R7 R9 R10
        for (int v = 0; v < 12; v++) begin
            bus_write(4'd5, {31'd0, VEC[v].boost});
            src = VEC[v].src;
            settle();
            check("R2 fiq_req", {31'd0, fiq_req}, {31'd0, VEC[v].fv});
            check("R2 irq_req", {31'd0, irq_req}, {31'd0, VEC[v].nv});
            bus_read(4'd10, d); check("R5 R7 R9 R10 fast winner", d, win(VEC[v].fv, VEC[v].fi));
            bus_read(4'd11, d); check("R5 R7 R9 R10 normal winner", d, win(VEC[v].nv, VEC[v].ni));
        end
        bus_write(4'd5, 32'h0);

        // R6 one-cycle latency of the winner word
        src = '0;
        settle();
        src = (64'd1 << 3);
        #1;
        check("R6 request immediate", {31'd0, fiq_req}, 32'h1);
        bus_read(4'd10, d); check("R6 winner not yet", d, 32'h0);
        @(posedge clk);
        @(negedge clk);
        bus_read(4'd10, d); check("R6 winner after edge", d, win(1'b1, 6'd3));

        // R8 slot table ordering
        bus_write(4'd4, 32'h00FA3215);
        src = (64'd1<<0)|(64'd1<<2)|(64'd1<<5);
        settle();
        bus_read(4'd11, d); check("R8 slot0 names 5", d, win(1'b1, 6'd5));
        src = (64'd1<<0)|(64'd1<<2);
        settle();
        bus_read(4'd11, d); check("R8 slot1 names 2", d, win(1'b1, 6'd2));
        bus_write(4'd4, 32'h00B6DB6D);
        src = (64'd1<<1);
        settle();
        check("R8 unnamed still requests", {31'd0, irq_req}, 32'h1);
        bus_read(4'd11, d); check("R8 unnamed not reported", d, 32'h0);
        src = (64'd1<<1)|(64'd1<<8);
        settle();
        bus_read(4'd11, d); check("R8 falls to line 8", d, win(1'b1, 6'd8));

        // R1 reset during activity
        bus_write(4'd5, 32'h1);
        src = (64'd1<<3)|(64'd1<<40);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        bus_read(4'd10, d); check("R1 reset fast winner", d, 32'h0);
        bus_read(4'd11, d); check("R1 reset normal winner", d, 32'h0);
        bus_read(4'd4, d);  check("R1 reset slots", d, 32'h00FAC688);
        bus_read(4'd5, d);  check("R1 reset boost", d, 32'h0);
        check("R1 reset requests", {30'd0, fiq_req, irq_req}, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule